// File: doc/BRIEF.md
# Index/Data Configuration Register Port

This block is a byte-wide configuration register file reached through two adjacent I/O addresses. A byte written to the lower address (the index port) picks one of 256 register slots. The upper address (the data port) then reads or writes the chosen slot. The block keeps most slots read-only through a fixed protection map. Two serial-port base slots are locked to fixed values. A set of defined reset values is loaded whenever reset is applied.

The whole two-address window is disabled after reset. A host-bridge configuration write turns it on or off. When that write lands on offset 0x85, its bit 1 becomes the window enable, so the port stays invisible until firmware opens it. The I/O side is a plain synchronous strobe bus and has no back-pressure: every strobe is taken in the cycle it is seen. Read data is registered. When a data-port write is refused, a one-cycle pulse reports it.

Top module: `cfg_idx_port`

## Requirements
- R1: After reset the index is 0x00, the window is disabled, `io_rdata` is 0xFF and `wr_drop` is 0.
- R2: A bridge configuration write to offset 0x85 sets the window enable to bit 1 of its data. The enable takes effect for I/O strobes from the next cycle on. Bridge writes to any other offset leave the enable unchanged.
- R3: While the window is disabled, a read strobe at either port loads 0xFF into `io_rdata`. A write strobe changes no register and does not move the index. No drop pulse is raised.
- R4: With the window enabled, a write to the index port (address 0x3F0) stores `io_wdata` as the index. A read of the index port returns the current index.
- R5: A read of the data port (address 0x3F1) returns the slot selected by the index in `io_rdata` on the cycle after the strobe. If a write to the data port happens in the same cycle, the read returns the value from before that write.
- R6: Writes through the data port take effect at indices 0xE0–0xE3, 0xE6, 0xEE–0xF2, 0xF4, 0xF6, 0xF8 and 0xFC.
- R7: Writes through the data port to any other index, except 0xE7 and 0xE8, are refused. These include 0x00–0xDF, 0xE4, 0xE5, 0xE9–0xED, 0xF3, 0xF5, 0xF7, 0xF9–0xFB and 0xFD–0xFF. The slot keeps reading its reset value (0x00).
- R8: Index 0xE7 accepts only 0xFE and index 0xE8 accepts only 0xBE. Any other value written to these two slots is refused, and the slot keeps its locked value.
- R9: At reset the slots load these values: 0xE0=0x3C, 0xE2=0x03, 0xE3=0xFC, 0xE6=0xDE, 0xE7=0xFE, 0xE8=0xBE. Every other slot loads 0x00.
- R10: Each refused data-port write raises `wr_drop` for exactly the one cycle after the write strobe. Accepted writes never raise it. Writes at the index port never raise it.
- R11: With the window enabled, a read strobe at an address outside the pair loads 0xFF into `io_rdata`. A write strobe at such an address changes no register and raises no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bcfg_we | input | 1 | Host-bridge configuration byte write strobe |
| bcfg_off | input | 8 | Host-bridge configuration offset |
| bcfg_wdata | input | 8 | Host-bridge configuration write byte |
| io_addr | input | 16 | I/O address |
| io_wr | input | 1 | I/O write strobe |
| io_rd | input | 1 | I/O read strobe |
| io_wdata | input | 8 | I/O write byte |
| io_rdata | output | 8 | Registered I/O read byte, updated on read strobes |
| wr_drop | output | 1 | One-cycle pulse for a refused data-port write |

## Verification
Assertions check the following on every cycle:
- the index holds steady while the window is closed;
- a closed-window read produces 0xFF;
- an index-port write loads the index;
- a bridge write at the enable offset moves the enable;
- a drop pulse is always preceded by an enabled data-port write.

Only the bench scenarios can show the rest: the irregular protection map slot by slot, the value gating on the two locked base slots, the reset contents, the old-value result of a same-cycle read and write, and a window closed and reopened with the index preserved.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;
  localparam int CFG_DW   = 8;
  localparam int CFG_IW   = 8;
  localparam logic [CFG_IW-1:0] HI_BASE = 8'hE0;
  localparam int SLOTS    = (1 << CFG_IW) - int'(HI_BASE);

  // slots below HI_BASE are all read-only zero
  function automatic logic slot_writable(input logic [CFG_IW-1:0] idx);
    logic ok;
    ok = 1'b0;
    case (idx)
      8'hE0, 8'hE1, 8'hE2, 8'hE3, 8'hE6, 8'hE7, 8'hE8,
      8'hEE, 8'hEF, 8'hF0, 8'hF1, 8'hF2, 8'hF4, 8'hF6,
      8'hF8, 8'hFC: ok = 1'b1;
      default:      ok = 1'b0;
    endcase
    return ok;
  endfunction

  function automatic logic slot_locked(input logic [CFG_IW-1:0] idx);
    return (idx == 8'hE7) || (idx == 8'hE8);
  endfunction

  function automatic logic [CFG_DW-1:0] slot_reset(input logic [CFG_IW-1:0] idx);
    logic [CFG_DW-1:0] v;
    case (idx)
      8'hE0:   v = 8'h3C;
      8'hE2:   v = 8'h03;
      8'hE3:   v = 8'hFC;
      8'hE6:   v = 8'hDE;
      8'hE7:   v = 8'hFE;
      8'hE8:   v = 8'hBE;
      default: v = 8'h00;
    endcase
    return v;
  endfunction
endpackage

// File: rtl/cfg_win_decode.sv
module cfg_win_decode #(
  parameter int ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h03F0,
  parameter int OFF_W     = 8,
  parameter logic [OFF_W-1:0] EN_OFF = 8'h85,
  parameter int EN_BIT    = 1,
  parameter int DW        = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bcfg_we,
  input  logic [OFF_W-1:0]  bcfg_off,
  input  logic [DW-1:0]     bcfg_wdata,
  input  logic [ADDR_W-1:0] io_addr,
  output logic              win_en,
  output logic              hit_idx,
  output logic              hit_dat
);
  localparam logic [ADDR_W-1:0] DAT_ADDR = BASE_ADDR + ADDR_W'(1);

  logic en_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                                en_q <= 1'b0;
    else if (bcfg_we && bcfg_off == EN_OFF)    en_q <= bcfg_wdata[EN_BIT];
  end

  assign win_en  = en_q;
  assign hit_idx = en_q && (io_addr == BASE_ADDR);
  assign hit_dat = en_q && (io_addr == DAT_ADDR);

  // R2
  en_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bcfg_we && bcfg_off == EN_OFF) |=> (win_en == $past(bcfg_wdata[EN_BIT])));
endmodule

// File: rtl/cfg_slot_bank.sv
module cfg_slot_bank
  import cfg_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [CFG_IW-1:0] wr_idx,
  input  logic [CFG_DW-1:0] wr_data,
  input  logic [CFG_IW-1:0] rd_idx,
  output logic [CFG_DW-1:0] rd_data,
  output logic              refuse
);
  localparam int SLOT_AW = $clog2(SLOTS);

  logic [CFG_DW-1:0] slot_v [SLOTS];
  logic              wr_ok;
  logic [CFG_IW-1:0] rd_off;

  always_comb begin
    wr_ok = slot_writable(wr_idx) &&
            (!slot_locked(wr_idx) || (wr_data == slot_reset(wr_idx)));
  end

  assign refuse = wr_stb && !wr_ok;

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    localparam logic [CFG_IW-1:0] IDX = CFG_IW'(int'(HI_BASE) + i);
    if (slot_writable(IDX) && !slot_locked(IDX)) begin : g_rw
      logic [CFG_DW-1:0] q;
      always_ff @(posedge clk) begin
        if (!rst_n)                          q <= slot_reset(IDX);
        else if (wr_stb && wr_idx == IDX)    q <= wr_data;
      end
      assign slot_v[i] = q;
    end else begin : g_ro
      assign slot_v[i] = slot_reset(IDX);
    end
  end

  assign rd_off = rd_idx - HI_BASE;

  always_comb begin
    rd_data = '0;
    if (rd_idx >= HI_BASE) rd_data = slot_v[rd_off[SLOT_AW-1:0]];
  end
endmodule

// File: rtl/cfg_idx_port.sv
module cfg_idx_port
  import cfg_port_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h03F0,
  parameter int OFF_W  = 8,
  parameter logic [OFF_W-1:0] EN_OFF = 8'h85,
  parameter int EN_BIT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bcfg_we,
  input  logic [OFF_W-1:0]  bcfg_off,
  input  logic [CFG_DW-1:0] bcfg_wdata,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [CFG_DW-1:0] io_wdata,
  output logic [CFG_DW-1:0] io_rdata,
  output logic              wr_drop
);
  localparam logic [CFG_DW-1:0] IDLE_BYTE = '1;

  logic              win_en, hit_idx, hit_dat;
  logic [CFG_IW-1:0] idx_q;
  logic [CFG_DW-1:0] bank_rd;
  logic              bank_refuse;
  logic [CFG_DW-1:0] rd_next;

  cfg_win_decode #(
    .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .OFF_W(OFF_W),
    .EN_OFF(EN_OFF), .EN_BIT(EN_BIT), .DW(CFG_DW)
  ) u_dec (
    .clk(clk), .rst_n(rst_n), .bcfg_we(bcfg_we), .bcfg_off(bcfg_off),
    .bcfg_wdata(bcfg_wdata), .io_addr(io_addr), .win_en(win_en),
    .hit_idx(hit_idx), .hit_dat(hit_dat)
  );

  cfg_slot_bank u_bank (
    .clk(clk), .rst_n(rst_n), .wr_stb(io_wr && hit_dat), .wr_idx(idx_q),
    .wr_data(io_wdata), .rd_idx(idx_q), .rd_data(bank_rd), .refuse(bank_refuse)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                 idx_q <= '0;
    else if (io_wr && hit_idx)  idx_q <= io_wdata;
  end

  always_comb begin
    rd_next = IDLE_BYTE;
    if (hit_idx)      rd_next = idx_q;
    else if (hit_dat) rd_next = bank_rd;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      io_rdata <= IDLE_BYTE;
      wr_drop  <= 1'b0;
    end else begin
      if (io_rd) io_rdata <= rd_next;
      wr_drop <= bank_refuse;
    end
  end

  // R3
  idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !win_en |=> $stable(idx_q));
  // R3
  off_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && !win_en) |=> (io_rdata == IDLE_BYTE));
  // R4
  idx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && win_en && io_addr == BASE_ADDR) |=> (idx_q == $past(io_wdata)));
  // R10
  drop_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_drop |-> $past(io_wr && win_en && io_addr == BASE_ADDR + ADDR_W'(1)));
endmodule

// File: tb/cfg_idx_port_tb.sv
module cfg_idx_port_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bcfg_we = 1'b0;
  logic [7:0]  bcfg_off = '0;
  logic [7:0]  bcfg_wdata = '0;
  logic [15:0] io_addr = '0;
  logic        io_wr = 1'b0;
  logic        io_rd = 1'b0;
  logic [7:0]  io_wdata = '0;
  logic [7:0]  io_rdata;
  logic        wr_drop;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  cfg_idx_port u_dut (
    .clk(clk), .rst_n(rst_n), .bcfg_we(bcfg_we), .bcfg_off(bcfg_off),
    .bcfg_wdata(bcfg_wdata), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .wr_drop(wr_drop)
  );

  // op: 0 bridge cfg write, 1 io write (exp[0] = expected drop), 2 io read
  typedef struct packed {
    logic [1:0]  op;
    logic [15:0] addr;
    logic [7:0]  dat;
    logic [7:0]  exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 44;
  localparam vec_t VT [NV] = '{
    '{2'd2, 16'h03F1, 8'h00, 8'hFF, 8'd3},  // R3 closed read
    '{2'd1, 16'h03F0, 8'hE0, 8'h00, 8'd3},  // R3 closed write
    '{2'd0, 16'h0085, 8'h02, 8'h00, 8'd2},  // R2 open
    '{2'd2, 16'h03F0, 8'h00, 8'h00, 8'd3},  // R3 index held at 0
    '{2'd2, 16'h03F1, 8'h00, 8'h00, 8'd9},  // R9 slot 0x00
    '{2'd1, 16'h03F0, 8'hE0, 8'h00, 8'd4},  // R4
    '{2'd2, 16'h03F0, 8'h00, 8'hE0, 8'd4},
    '{2'd2, 16'h03F1, 8'h00, 8'h3C, 8'd9},
    '{2'd1, 16'h03F1, 8'h55, 8'h00, 8'd6},  // R6
    '{2'd2, 16'h03F1, 8'h00, 8'h55, 8'd6},
    '{2'd1, 16'h03F0, 8'hE7, 8'h00, 8'd4},
    '{2'd2, 16'h03F1, 8'h00, 8'hFE, 8'd9},
    '{2'd1, 16'h03F1, 8'h12, 8'h01, 8'd8},  // R8 refused
    '{2'd2, 16'h03F1, 8'h00, 8'hFE, 8'd8},
    '{2'd1, 16'h03F1, 8'hFE, 8'h00, 8'd8},  // R8 accepted
    '{2'd1, 16'h03F0, 8'hE8, 8'h00, 8'd4},
    '{2'd2, 16'h03F1, 8'h00, 8'hBE, 8'd9},
    '{2'd1, 16'h03F1, 8'h00, 8'h01, 8'd8},
    '{2'd2, 16'h03F1, 8'h00, 8'hBE, 8'd8},
    '{2'd1, 16'h03F0, 8'hE2, 8'h00, 8'd4},
    '{2'd2, 16'h03F1, 8'h00, 8'h03, 8'd9},
    '{2'd1, 16'h03F0, 8'hE3, 8'h00, 8'd4},
    '{2'd2, 16'h03F1, 8'h00, 8'hFC, 8'd9},
    '{2'd1, 16'h03F0, 8'hE6, 8'h00, 8'd4},
    '{2'd2, 16'h03F1, 8'h00, 8'hDE, 8'd9},
    '{2'd1, 16'h03F0, 8'hE4, 8'h00, 8'd4},
    '{2'd1, 16'h03F1, 8'hAA, 8'h01, 8'd7},  // R7
    '{2'd2, 16'h03F1, 8'h00, 8'h00, 8'd7},
    '{2'd1, 16'h03F0, 8'h10, 8'h00, 8'd4},
    '{2'd1, 16'h03F1, 8'h77, 8'h01, 8'd7},
    '{2'd2, 16'h03F1, 8'h00, 8'h00, 8'd7},
    '{2'd1, 16'h03F0, 8'hFF, 8'h00, 8'd4},
    '{2'd1, 16'h03F1, 8'h01, 8'h01, 8'd7},
    '{2'd1, 16'h03F0, 8'hFC, 8'h00, 8'd4},
    '{2'd1, 16'h03F1, 8'hA5, 8'h00, 8'd6},
    '{2'd2, 16'h03F1, 8'h00, 8'hA5, 8'd6},
    '{2'd2, 16'h03F2, 8'h00, 8'hFF, 8'd11}, // R11
    '{2'd1, 16'h02F0, 8'h33, 8'h00, 8'd11},
    '{2'd2, 16'h03F0, 8'h00, 8'hFC, 8'd11},
    '{2'd0, 16'h0084, 8'h00, 8'h00, 8'd2},  // R2 other offset
    '{2'd2, 16'h03F0, 8'h00, 8'hFC, 8'd2},
    '{2'd0, 16'h0085, 8'h00, 8'h00, 8'd2},  // R2 close
    '{2'd2, 16'h03F1, 8'h00, 8'hFF, 8'd3},
    '{2'd1, 16'h03F0, 8'h11, 8'h00, 8'd3}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bcfg(input logic [7:0] off, input logic [7:0] d);
    @(negedge clk);
    bcfg_we = 1'b1; bcfg_off = off; bcfg_wdata = d;
    @(negedge clk);
    bcfg_we = 1'b0;
  endtask

  task automatic io(input logic wr, input logic rd, input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_wr = wr; io_rd = rd; io_addr = a; io_wdata = d;
    @(negedge clk);
    io_wr = 1'b0; io_rd = 1'b0;
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check("R1 rdata", io_rdata, 8'hFF);
    check("R1 drop", {7'd0, wr_drop}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VT[i].req, i);
      case (VT[i].op)
        2'd0: bcfg(VT[i].addr[7:0], VT[i].dat);
        2'd1: begin
          io(1'b1, 1'b0, VT[i].addr, VT[i].dat);
          check(tag, {7'd0, wr_drop}, VT[i].exp);
        end
        default: begin
          io(1'b0, 1'b1, VT[i].addr, VT[i].dat);
          check(tag, io_rdata, VT[i].exp);
        end
      endcase
    end

    // R3 reopen: index survived the closed-window write
    bcfg(8'h85, 8'h02);
    io(1'b0, 1'b1, 16'h03F0, 8'h00);
    check("R3 index kept", io_rdata, 8'hFC);

    // R5 same-cycle read and write of the data port
    io(1'b1, 1'b0, 16'h03F0, 8'hF6);
    io(1'b1, 1'b0, 16'h03F1, 8'h10);
    io(1'b1, 1'b1, 16'h03F1, 8'h20);
    check("R5 old value", io_rdata, 8'h10);
    io(1'b0, 1'b1, 16'h03F1, 8'h00);
    check("R5 new value", io_rdata, 8'h20);

    // R10 single-cycle pulse
    io(1'b1, 1'b0, 16'h03F0, 8'hF5);
    io(1'b1, 1'b0, 16'h03F1, 8'h42);
    check("R10 pulse", {7'd0, wr_drop}, 8'h01);
    @(negedge clk);
    check("R10 pulse ends", {7'd0, wr_drop}, 8'h00);

    // R6 another writable slot
    io(1'b1, 1'b0, 16'h03F0, 8'hF4);
    io(1'b1, 1'b0, 16'h03F1, 8'h5A);
    io(1'b0, 1'b1, 16'h03F1, 8'h00);
    check("R6 F4", io_rdata, 8'h5A);

    // R1 and R9 after a second reset
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    check("R1 rdata after reset", io_rdata, 8'hFF);
    io(1'b0, 1'b1, 16'h03F1, 8'h00);
    check("R1 window closed", io_rdata, 8'hFF);
    bcfg(8'h85, 8'h02);
    io(1'b0, 1'b1, 16'h03F0, 8'h00);
    check("R1 index zero", io_rdata, 8'h00);
    io(1'b1, 1'b0, 16'h03F0, 8'hF4);
    io(1'b0, 1'b1, 16'h03F1, 8'h00);
    check("R9 F4 reset", io_rdata, 8'h00);
    io(1'b1, 1'b0, 16'h03F0, 8'hE0);
    io(1'b0, 1'b1, 16'h03F1, 8'h00);
    check("R9 E0 reset", io_rdata, 8'h3C);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule